// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog counter with a byte-wide register bus. Software keeps the system alive by writing one fixed key byte, 0xAC, to a restart register before the count reaches its limit. If the count reaches the limit, the block emits a one-cycle reset request. The same request fires on misuse of the registers:
- a wrong byte written to the restart register,
- a single-bit read-modify-write access to the restart register,
- a second write to the once-only mode register.

The count advances only on cycles where the source-run input is high. That input stands for the watchdog's source clock and is synchronous to the bus clock. A violation that occurs while the source is halted is recorded, and the request is raised once the source runs again. A static configuration input selects one of two behaviours. In the first, the watchdog can never be stopped. In the second, software may stop it by setting bit 4 of the mode register. A stopped watchdog holds its count and ignores every violation.

Each reset request clears the whole block back to its post-reset state in the same cycle the request is raised.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `rst_req` is 0, the count is 0, the restart register reads 0x9A and the mode register reads 0x07.
- R2: Address 0 is the mode register and address 1 is the restart register. Read data is registered and appears one cycle after `bus_rd`. The restart register always reads 0x9A, whatever was written to it.
- R3: A full-byte write (`bus_bitop`=0) of 0xAC to address 1 clears the count to 0, and counting restarts from 0.
- R4: The count rises by one on each cycle where `src_run` is 1 and the watchdog is not stopped. The limit is 2^(10+S), where S = mode[2:0]; any S of 7 or more gives 2^16. `rst_req` rises one cycle after the count reaches the limit.
- R5: Writing any byte other than 0xAC to address 1 raises `rst_req` in the next cycle.
- R6: A write to address 1 with `bus_bitop`=1 raises `rst_req` in the next cycle, even when the data is 0xAC.
- R7: The first write to address 0 after reset is stored, and it freezes the limit select. A second write raises `rst_req` in the next cycle.
- R8: When `cfg_always_on`=0 and mode bit 4 is 1, the watchdog is stopped. The count holds, no limit is reached, and bad keys, bit accesses and second mode writes raise no request and change no register.
- R9: When `cfg_always_on`=1, mode bit 4 has no effect. Counting and all violation causes work as normal.
- R10: A violation or a reached limit that occurs while `src_run`=0 is recorded. `rst_req` is raised one cycle after the first cycle in which `src_run` is 1 again. The count holds while `src_run`=0.
- R11: `rst_req` is a single-cycle pulse. In the cycle it is high, the block is already back in its R1 state, and bus writes in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_always_on | input | 1 | 1: watchdog cannot be stopped; 0: mode bit 4 may stop it |
| src_run | input | 1 | Source clock running (count enable) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_bitop | input | 1 | Marks the write as a single-bit read-modify-write |
| bus_rdata | output | 8 | Registered read data |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The properties assume that `cfg_always_on` changes only while `rst` is held, and that `bus_wr` and `bus_rd` are never both high in one cycle. The bench changes the configuration only inside a reset pulse and issues exactly one bus access per transaction. The bench also issues no writes in the cycle where `rst_req` is high, although the block ignores such writes anyway. In the random phase, the gap between restart writes always stays below the smallest limit, so every expected request comes from a directed cause.

// File: rtl/kw_pkg.sv
package kw_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE = 2'd0,
    REG_KICK = 2'd1
  } reg_addr_e;

  localparam logic [DATA_W-1:0] KICK_KEY  = 8'hAC;
  localparam logic [DATA_W-1:0] KICK_READ = 8'h9A;
  localparam logic [DATA_W-1:0] MODE_RST  = 8'h07;
  localparam int                STOP_BIT  = 4;
endpackage

// File: rtl/kw_regs.sv
module kw_regs
  import kw_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              busy_i,
  input  logic              cfg_always_on_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_bitop_i,
  output logic              stopped_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              kick_o,
  output logic              viol_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mode_q;
  logic              locked_q;
  logic              wr_mode, wr_kick, kick_good;

  assign stopped_o = !cfg_always_on_i && mode_q[STOP_BIT];
  assign sel_o     = mode_q[SEL_W-1:0];

  assign wr_mode   = bus_wr_i && !busy_i && (reg_addr_e'(bus_addr_i) == REG_MODE);
  assign wr_kick   = bus_wr_i && !busy_i && (reg_addr_e'(bus_addr_i) == REG_KICK);
  assign kick_good = wr_kick && !bus_bitop_i && (bus_wdata_i == KICK_KEY);
  assign kick_o    = kick_good && !stopped_o;
  assign viol_o    = !stopped_o &&
                     ((wr_kick && !kick_good) || (wr_mode && locked_q));

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      mode_q   <= MODE_RST;
      locked_q <= 1'b0;
    end else if (wr_mode && !locked_q) begin
      mode_q   <= bus_wdata_i;
      locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (bus_rd_i) begin
      case (reg_addr_e'(bus_addr_i))
        REG_MODE: rdata_o <= mode_q;
        REG_KICK: rdata_o <= KICK_READ;
        default:  rdata_o <= '0;
      endcase
    end else begin
      rdata_o <= '0;
    end
  end

  // R7
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !clr_i) |=> $stable(mode_q));

  // R2
  kick_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && reg_addr_e'(bus_addr_i) == REG_KICK) |=> (rdata_o == KICK_READ));
endmodule

// File: rtl/kw_counter.sv
module kw_counter #(
  parameter int CNT_W    = 17,
  parameter int SEL_W    = 3,
  parameter int TAP_BASE = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             kick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ovf_o
);
  localparam int TAP_MAX = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_comb begin
    int tap_v;
    tap_v = TAP_BASE + int'(sel_i);
    if (tap_v > TAP_MAX) tap_v = TAP_MAX;
    limit        = '0;
    limit[tap_v] = 1'b1;
  end

  assign ovf_o = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr_i || kick_i) cnt_q <= '0;
    else if (en_i)              cnt_q <= cnt_q + 1'b1;
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i && !kick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/kw_reqgen.sv
module kw_reqgen (
  input  logic clk,
  input  logic rst,
  input  logic src_run_i,
  input  logic viol_i,
  input  logic ovf_i,
  output logic fire_o,
  output logic rst_req_o
);
  logic pend_q;

  assign fire_o = src_run_i && (viol_i || pend_q || ovf_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= fire_o;
      if (fire_o)      pend_q <= 1'b0;
      else if (viol_i) pend_q <= 1'b1;
    end
  end

  // R11
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  // R10
  src_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(src_run_i));

  // R10
  pend_release_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && src_run_i) |=> rst_req_o);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kw_pkg::*;
#(
  parameter int CNT_W    = 17,
  parameter int SEL_W    = 3,
  parameter int TAP_BASE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_always_on,
  input  logic              src_run,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_bitop,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic             stopped, kick, viol, ovf, fire;
  logic [SEL_W-1:0] sel;

  kw_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .clr_i(fire), .busy_i(rst_req),
    .cfg_always_on_i(cfg_always_on),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_bitop_i(bus_bitop),
    .stopped_o(stopped), .sel_o(sel), .kick_o(kick), .viol_o(viol),
    .rdata_o(bus_rdata)
  );

  kw_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W), .TAP_BASE(TAP_BASE)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(fire),
    .en_i(src_run && !stopped), .kick_i(kick), .sel_i(sel), .ovf_o(ovf)
  );

  kw_reqgen u_req (
    .clk(clk), .rst(rst), .src_run_i(src_run), .viol_i(viol),
    .ovf_i(ovf), .fire_o(fire), .rst_req_o(rst_req)
  );

  // R5
  bad_kick_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd1 && (bus_wdata != KICK_KEY || bus_bitop)
     && cfg_always_on && src_run && !rst_req) |=> rst_req);
endmodule

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_always_on = 1'b1;
  logic       src_run = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_bitop = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keyed_watchdog u0 (
    .clk(clk), .rst(rst), .cfg_always_on(cfg_always_on), .src_run(src_run),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_bitop(bus_bitop),
    .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  function automatic int exp_limit(input int sel);
    int t;
    t = 10 + sel;
    if (t > 16) t = 16;
    return 1 << t;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic hw_reset(input logic cfg);
    rst = 1'b1;
    cfg_always_on = cfg;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic bop);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_bitop = bop;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_bitop = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic overflow_run(input string tag, input int sel);
    int lim;
    lim = exp_limit(sel);
    wr(2'd1, 8'hAC, 1'b0);
    idle(lim);
    chk({tag, " before limit"}, rst_req, 0);
    idle(1);
    chk({tag, " at limit"}, rst_req, 1);
    idle(1);
  endtask

  initial begin
    logic [7:0] d;
    int seed;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    hw_reset(1'b1);

    // R1 / R2: reset state and read map
    chk("R1 rst_req idle", rst_req, 0);
    rd(2'd1, d); chk("R1 R2 restart reads 9A", d, 8'h9A);
    rd(2'd0, d); chk("R1 mode reset", d, 8'h07);

    // R3 key accepted, R2 readback unchanged
    wr(2'd1, 8'hAC, 1'b0);
    chk("R3 key no request", rst_req, 0);
    rd(2'd1, d); chk("R2 restart reads 9A after key", d, 8'h9A);

    // R5 bad key, R11 pulse and state clear
    wr(2'd1, 8'h55, 1'b0);
    chk("R5 bad key request", rst_req, 1);
    idle(1);
    chk("R11 single pulse", rst_req, 0);
    wr(2'd0, 8'h01, 1'b0);
    chk("R11 mode writable after pulse", rst_req, 0);
    rd(2'd0, d); chk("R11 mode stored", d, 8'h01);

    // R6 bit access with key value
    wr(2'd1, 8'hAC, 1'b1);
    chk("R6 bit access request", rst_req, 1);
    idle(1);
    rd(2'd0, d); chk("R11 mode back to reset", d, 8'h07);

    // R7 once-only mode
    wr(2'd0, 8'h00, 1'b0);
    chk("R7 first mode write", rst_req, 0);
    rd(2'd0, d); chk("R7 mode value", d, 8'h00);
    wr(2'd0, 8'h03, 1'b0);
    chk("R7 second mode write request", rst_req, 1);
    idle(1);

    // R4 limits for several selects
    wr(2'd0, 8'h00, 1'b0); overflow_run("R4 sel0", 0);
    wr(2'd0, 8'h02, 1'b0); overflow_run("R4 sel2", 2);
    wr(2'd0, 8'h07, 1'b0); overflow_run("R4 sel7 clamp", 7);

    // R3 restart defers the limit
    wr(2'd0, 8'h00, 1'b0);
    wr(2'd1, 8'hAC, 1'b0);
    idle(1000);
    wr(2'd1, 8'hAC, 1'b0);
    idle(1000);
    chk("R3 restart keeps alive", rst_req, 0);
    idle(24);
    chk("R3 count from last key", rst_req, 0);
    idle(1);
    chk("R3 limit after last key", rst_req, 1);
    idle(1);

    // R8 stoppable and stopped
    hw_reset(1'b0);
    wr(2'd0, 8'h10, 1'b0);
    idle(2000);
    chk("R8 stopped no limit", rst_req, 0);
    wr(2'd1, 8'h33, 1'b0); chk("R8 bad key ignored", rst_req, 0);
    wr(2'd1, 8'hAC, 1'b1); chk("R8 bit access ignored", rst_req, 0);
    wr(2'd0, 8'h00, 1'b0); chk("R8 second mode ignored", rst_req, 0);
    idle(1);
    chk("R8 still quiet", rst_req, 0);
    rd(2'd0, d); chk("R8 mode unchanged", d, 8'h10);

    // R9 always-on ignores stop bit
    hw_reset(1'b1);
    wr(2'd0, 8'h10, 1'b0);
    overflow_run("R9 stop bit no effect", 0);
    wr(2'd0, 8'h10, 1'b0);
    wr(2'd1, 8'h00, 1'b0);
    chk("R9 bad key with stop bit", rst_req, 1);
    idle(1);

    // R10 violation while source halted
    src_run = 1'b0;
    wr(2'd1, 8'h12, 1'b0);
    chk("R10 held while halted", rst_req, 0);
    idle(5);
    chk("R10 still held", rst_req, 0);
    src_run = 1'b1;
    idle(1);
    chk("R10 released on resume", rst_req, 1);
    idle(1);

    // R10 count holds while halted
    wr(2'd0, 8'h00, 1'b0);
    wr(2'd1, 8'hAC, 1'b0);
    idle(500);
    src_run = 1'b0;
    idle(3000);
    chk("R10 no limit while halted", rst_req, 0);
    src_run = 1'b1;
    idle(524);
    chk("R10 count resumed not reached", rst_req, 0);
    idle(1);
    chk("R10 count resumed reached", rst_req, 1);
    idle(1);

    // Random phase: R3 restarts, R2 reads, R5 random bad bytes
    hw_reset(1'b1);
    wr(2'd0, 8'h00, 1'b0);
    for (int i = 0; i < 20; i++) begin
      logic [7:0] b;
      idle($urandom_range(1, 900));
      if ($urandom_range(0, 1) == 1) begin
        rd(2'd1, d); chk("R2 random read", d, 8'h9A);
      end
      wr(2'd1, 8'hAC, 1'b0);
      chk("R3 random restart", rst_req, 0);
      if (i % 5 == 4) begin
        b = 8'($urandom_range(0, 255));
        if (b == 8'hAC) b = 8'h00;
        wr(2'd1, b, 1'b0);
        chk("R5 random bad byte", rst_req, 1);
        idle(1);
        wr(2'd0, 8'h00, 1'b0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired (all requirements): actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule